// File: doc/BRIEF.md
# Configurable Input Capture Cell Bank

This block sits between three 8-bit pin ports and the input bus of a programmable logic array. Each of its 24 cells, one per pin, either passes its pin straight onto the logic input bus, holds it in a level-sensitive latch, or captures it in an edge-triggered register. Cells are organised in groups of four (the low and high nibble of each port). Every group picks its own strobe: a dedicated product-term signal coming from the logic array, or the shared microcontroller address strobe. With the address strobe, a group can catch upper address lines from a multiplexed bus and present them to the logic array as inputs.

A processor configures the bank through a small write port: one 8-bit mode register per group and one strobe-source register. It reads the cell outputs back one port at a time through a registered read port that feeds the internal data bus. The product-term strobes arrive as plain inputs; the logic that makes them is outside this block.

Top module: `input_cell_bank`

## Requirements
- R1: After a synchronous active-low reset, every cell is in pass-through mode, every group uses the address strobe, and `rd_data_o` is zero.
- R2: A cell in pass-through mode drives its logic bus bit combinationally from its pin, with no clock delay.
- R3: In latch mode (code 01), a cell takes its pin value at each clock edge where its group's selected strobe is high, and holds it at every edge where that strobe is low.
- R4: In register mode (code 10), a cell takes its pin value only at a clock edge where its group's selected strobe is high and was low at the previous edge; it holds while the strobe stays high or low.
- R5: Bit g of the strobe-source register (config address 6) set to 1 makes group g use `pterm_strb_i[g]`, cleared to 0 makes it use `addr_strb_i`; the unselected strobe has no effect on that group. Group g holds cells 4g..4g+3, so port p bits 3..0 form group 2p and bits 7..4 form group 2p+1.
- R6: A strobe reaching one group changes no cell of any other group.
- R7: A config write at address k (0..5) sets the modes of group k, cell j of the group in data bits [2j+1:2j]; codes 00 and 11 both mean pass-through. A write at address 7 changes nothing.
- R8: A read with `rd_en_i` high and `rd_idx_i` equal to p (0..2) puts logic bus bits [8p+7:8p] on `rd_data_o` at the next clock edge; index 3 returns zero; without `rd_en_i` the read data holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 24 | Port pins, port p at bits [8p+7:8p] |
| addr_strb_i | input | 1 | Microcontroller address strobe |
| pterm_strb_i | input | 6 | Product-term strobe per four-cell group |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | 3 | Configuration register address |
| cfg_wdata_i | input | 8 | Configuration write data |
| rd_en_i | input | 1 | Readback request |
| rd_idx_i | input | 2 | Port index to read back |
| rd_data_o | output | 8 | Registered readback data |
| logic_bus_o | output | 24 | Cell outputs to the logic array input bus |

## Verification
The assertions assume that pins and both strobe kinds are synchronous to `clk`, so that each strobe level seen at a clock edge is the one the cells act on, and that a group's strobe source is not switched while its strobe is high. The stimulus changes pins, strobes and configuration only on falling clock edges, holds the strobes low across every strobe-source write, and keeps pins steady over each mode write so the value a cell holds when it leaves pass-through is known.

// File: rtl/icb_pkg.sv
// Package: shared encodings for the input capture cell bank.
// Assumes nothing beyond a 2-bit mode field per cell.
package icb_pkg;

    // Per-cell storage mode; code 2'b11 behaves as pass-through.
    typedef enum logic [1:0] {
        CM_PASS     = 2'b00,
        CM_LATCH    = 2'b01,
        CM_REG      = 2'b10,
        CM_PASS_ALT = 2'b11
    } cell_mode_e;

    localparam int unsigned MODE_W = 2;

endpackage

// File: rtl/icb_cfg_regs.sv
// Module: configuration registers of the bank.
// Holds one mode byte per group (address = group index) and one
// strobe-source register at address NUM_GRPS. Other addresses are ignored.
// Assumes NUM_GRPS does not exceed the write data width.
module icb_cfg_regs #(
    parameter int NUM_GRPS = 6,
    parameter int GRP_W    = 4,
    parameter int CFG_AW   = 3,
    localparam int CFG_DW  = 2 * GRP_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we_i,
    input  logic [CFG_AW-1:0]          cfg_addr_i,
    input  logic [CFG_DW-1:0]          cfg_wdata_i,
    output logic [NUM_GRPS*CFG_DW-1:0] mode_flat_o,
    output logic [NUM_GRPS-1:0]        src_sel_o
);

    localparam logic [CFG_AW-1:0] SEL_ADDR = CFG_AW'(NUM_GRPS);

    for (genvar g = 0; g < NUM_GRPS; g++) begin : g_mode
        // Mode byte for group g: reset to all pass-through.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mode_flat_o[g*CFG_DW +: CFG_DW] <= '0;
            end else if (cfg_we_i && cfg_addr_i == CFG_AW'(g)) begin
                mode_flat_o[g*CFG_DW +: CFG_DW] <= cfg_wdata_i;
            end
        end
    end

    // Strobe-source bits: 0 selects the address strobe (reset value).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_sel_o <= '0;
        end else if (cfg_we_i && cfg_addr_i == SEL_ADDR) begin
            src_sel_o <= cfg_wdata_i[NUM_GRPS-1:0];
        end
    end

endmodule

// File: rtl/icb_strobe_path.sv
// Module: per-group strobe selection and rising-edge detection.
// Assumes strobes are synchronous to clk; a rise is flagged when the
// selected level is high now and was low at the previous edge.
module icb_strobe_path #(
    parameter int NUM_GRPS = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                addr_strb_i,
    input  logic [NUM_GRPS-1:0] pterm_strb_i,
    input  logic [NUM_GRPS-1:0] src_sel_i,
    output logic [NUM_GRPS-1:0] lvl_o,
    output logic [NUM_GRPS-1:0] rise_o
);

    logic [NUM_GRPS-1:0] lvl_prev_q;

    for (genvar g = 0; g < NUM_GRPS; g++) begin : g_src
        // Source multiplexer: product term or address strobe.
        always_comb lvl_o[g] = src_sel_i[g] ? pterm_strb_i[g] : addr_strb_i;
    end

    // Previous selected level, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_prev_q <= '0;
        else        lvl_prev_q <= lvl_o;
    end

    // Rising edge of each selected strobe.
    always_comb rise_o = lvl_o & ~lvl_prev_q;

endmodule

// File: rtl/icb_cell.sv
// Module: one input capture cell.
// Pass-through drives the pin straight out; latch and register modes
// drive a stored bit. In pass-through the store tracks the pin so that
// a switch into a storing mode starts from the current pin value.
module icb_cell (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic [1:0] mode_i,
    input  logic       strb_lvl_i,
    input  logic       strb_rise_i,
    output logic       out_o
);
    import icb_pkg::*;

    cell_mode_e mode;
    logic       hold_q;

    // Decode the mode field.
    always_comb mode = cell_mode_e'(mode_i);

    // Storage element update per mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else begin
            case (mode)
                CM_LATCH: if (strb_lvl_i)  hold_q <= pin_i;
                CM_REG:   if (strb_rise_i) hold_q <= pin_i;
                default:  hold_q <= pin_i;
            endcase
        end
    end

    // Output select: stored bit in storing modes, pin otherwise.
    always_comb out_o = (mode == CM_LATCH || mode == CM_REG) ? hold_q : pin_i;

endmodule

// File: rtl/icb_readback.sv
// Module: registered processor readback of one port of cell outputs.
// Index values at or above NUM_PORTS read as zero.
module icb_readback #(
    parameter int NUM_PORTS = 3,
    parameter int PORT_W    = 8,
    parameter int IDX_W     = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_en_i,
    input  logic [IDX_W-1:0]            rd_idx_i,
    input  logic [NUM_PORTS*PORT_W-1:0] bus_i,
    output logic [PORT_W-1:0]           rd_data_o
);

    logic [PORT_W-1:0] slice;

    // Port slice selected by the index.
    always_comb begin
        slice = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (rd_idx_i == IDX_W'(p)) slice = bus_i[p*PORT_W +: PORT_W];
        end
    end

    // Read data register, updated only on a request.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_data_o <= '0;
        else if (rd_en_i) rd_data_o <= slice;
    end

endmodule

// File: rtl/input_cell_bank.sv
// Module: top of the input capture cell bank.
// Instantiates the configuration registers, the per-group strobe path,
// one cell per pin and the readback port. Group of cell c is c / GRP_W.
// Assumes PORT_W is a multiple of GRP_W.
module input_cell_bank #(
    parameter int NUM_PORTS = 3,
    parameter int PORT_W    = 8,
    parameter int GRP_W     = 4,
    localparam int NUM_CELLS = NUM_PORTS * PORT_W,
    localparam int NUM_GRPS  = NUM_CELLS / GRP_W,
    localparam int CFG_AW    = $clog2(NUM_GRPS + 2),
    localparam int CFG_DW    = 2 * GRP_W,
    localparam int IDX_W     = $clog2(NUM_PORTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CELLS-1:0] pin_i,
    input  logic                 addr_strb_i,
    input  logic [NUM_GRPS-1:0]  pterm_strb_i,
    input  logic                 cfg_we_i,
    input  logic [CFG_AW-1:0]    cfg_addr_i,
    input  logic [CFG_DW-1:0]    cfg_wdata_i,
    input  logic                 rd_en_i,
    input  logic [IDX_W-1:0]     rd_idx_i,
    output logic [PORT_W-1:0]    rd_data_o,
    output logic [NUM_CELLS-1:0] logic_bus_o
);

    logic [NUM_GRPS*CFG_DW-1:0] mode_flat;
    logic [NUM_GRPS-1:0]        src_sel;
    logic [NUM_GRPS-1:0]        grp_lvl;
    logic [NUM_GRPS-1:0]        grp_rise;

    icb_cfg_regs #(
        .NUM_GRPS (NUM_GRPS),
        .GRP_W    (GRP_W),
        .CFG_AW   (CFG_AW)
    ) cfg_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we_i    (cfg_we_i),
        .cfg_addr_i  (cfg_addr_i),
        .cfg_wdata_i (cfg_wdata_i),
        .mode_flat_o (mode_flat),
        .src_sel_o   (src_sel)
    );

    icb_strobe_path #(
        .NUM_GRPS (NUM_GRPS)
    ) strb_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_strb_i  (addr_strb_i),
        .pterm_strb_i (pterm_strb_i),
        .src_sel_i    (src_sel),
        .lvl_o        (grp_lvl),
        .rise_o       (grp_rise)
    );

    for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
        localparam int GRP = c / GRP_W;
        icb_cell cell_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .pin_i       (pin_i[c]),
            .mode_i      (mode_flat[2*c +: 2]),
            .strb_lvl_i  (grp_lvl[GRP]),
            .strb_rise_i (grp_rise[GRP]),
            .out_o       (logic_bus_o[c])
        );
    end

    icb_readback #(
        .NUM_PORTS (NUM_PORTS),
        .PORT_W    (PORT_W),
        .IDX_W     (IDX_W)
    ) rb_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (rd_en_i),
        .rd_idx_i  (rd_idx_i),
        .bus_i     (logic_bus_o),
        .rd_data_o (rd_data_o)
    );

endmodule

// File: rtl/input_cell_bank_chk.sv
// Module: assertion checker bound to input_cell_bank.
// Assumes pins and strobes are synchronous to clk.
module input_cell_bank_chk #(
    parameter int NUM_PORTS = 3,
    parameter int PORT_W    = 8,
    parameter int GRP_W     = 4,
    localparam int NUM_CELLS = NUM_PORTS * PORT_W,
    localparam int NUM_GRPS  = NUM_CELLS / GRP_W,
    localparam int IDX_W     = $clog2(NUM_PORTS + 1)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_CELLS-1:0]   pin_i,
    input logic [NUM_CELLS-1:0]   logic_bus_o,
    input logic [2*NUM_CELLS-1:0] mode_flat,
    input logic [NUM_GRPS-1:0]    grp_lvl,
    input logic [NUM_GRPS-1:0]    grp_rise,
    input logic                   rd_en_i,
    input logic [IDX_W-1:0]       rd_idx_i,
    input logic [PORT_W-1:0]      rd_data_o
);

    logic [PORT_W-1:0] exp_slice;

    // Expected readback slice for the current index.
    always_comb begin
        exp_slice = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (rd_idx_i == IDX_W'(p)) exp_slice = logic_bus_o[p*PORT_W +: PORT_W];
        end
    end

    for (genvar c = 0; c < NUM_CELLS; c++) begin : g_chk
        localparam int GRP = c / GRP_W;

        a_r2_pass_follows_pin: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_flat[2*c +: 2] == 2'b00 || mode_flat[2*c +: 2] == 2'b11)
            |-> logic_bus_o[c] == pin_i[c]);

        a_r3_latch_open_takes_pin: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_flat[2*c +: 2] == 2'b01 && grp_lvl[GRP])
            |=> (mode_flat[2*c +: 2] != 2'b01 || logic_bus_o[c] == $past(pin_i[c])));

        a_r4_reg_holds_without_rise: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_flat[2*c +: 2] == 2'b10 && !grp_rise[GRP])
            |=> (mode_flat[2*c +: 2] != 2'b10 || $stable(logic_bus_o[c])));

        a_r4_reg_captures_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_flat[2*c +: 2] == 2'b10 && grp_rise[GRP])
            |=> (mode_flat[2*c +: 2] != 2'b10 || logic_bus_o[c] == $past(pin_i[c])));
    end

    a_r8_read_port: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> rd_data_o == $past(exp_slice));

    a_r8_read_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rd_data_o));

endmodule

bind input_cell_bank input_cell_bank_chk #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W),
    .GRP_W     (GRP_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_i       (pin_i),
    .logic_bus_o (logic_bus_o),
    .mode_flat   (mode_flat),
    .grp_lvl     (grp_lvl),
    .grp_rise    (grp_rise),
    .rd_en_i     (rd_en_i),
    .rd_idx_i    (rd_idx_i),
    .rd_data_o   (rd_data_o)
);

// File: tb/input_cell_bank_tb_top.sv
// Bench: scoreboard for reads plus direct checks of the logic bus.
// Inputs change on falling edges; outputs are sampled on falling edges.
module input_cell_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] pin = '0;
    logic        addr_strb = 1'b0;
    logic [5:0]  pterm = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_idx = '0;
    logic [7:0]  rd_data;
    logic [23:0] bus;

    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;
    logic        rd_en_d = 1'b0;
    logic [7:0]  exp_q[$];
    string       req_q[$];

    always #2 clk = ~clk;

    input_cell_bank dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_i        (pin),
        .addr_strb_i  (addr_strb),
        .pterm_strb_i (pterm),
        .cfg_we_i     (cfg_we),
        .cfg_addr_i   (cfg_addr),
        .cfg_wdata_i  (cfg_wdata),
        .rd_en_i      (rd_en),
        .rd_idx_i     (rd_idx),
        .rd_data_o    (rd_data),
        .logic_bus_o  (bus)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    // Driver: issue a read and push its expected data to the scoreboard.
    task automatic do_read(input logic [1:0] idx, input logic [7:0] exp, input string req);
        rd_en = 1'b1; rd_idx = idx;
        exp_q.push_back(exp);
        req_q.push_back(req);
        tick();
        rd_en = 1'b0;
    endtask

    always @(posedge clk) rd_en_d <= rd_en;

    // Monitor: compare read data one cycle after each request.
    always @(negedge clk) begin
        if (rd_en_d) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R8: read data %0h with no expected item", rd_data);
            end else begin
                check(req_q.pop_front(), {24'h0, rd_data}, {24'h0, exp_q.pop_front()});
            end
        end
    end

    initial begin
        pin = 24'h3C_5A_A5;
        repeat (3) tick();
        check("R1 read data at reset", rd_data, 8'h00);
        rst_n = 1'b1;
        tick();
        check("R1 pass after reset", bus, 24'h3C_5A_A5);
        do_read(2'd0, 8'hA5, "R1 R8 read port0 after reset");

        // R2: pass-through is combinational.
        pin = 24'h0F_F0_81; #1;
        check("R2 pass pattern a", bus, 24'h0F_F0_81);
        pin = 24'h12_34_56; #1;
        check("R2 pass pattern b", bus, 24'h12_34_56);
        tick();
        cfg_write(3'd0, 8'hFF);
        pin = 24'h00_00_0E; #1;
        check("R7 code 11 is pass", bus, 24'h00_00_0E);

        // R3: group 2 (port1 low nibble) latch on address strobe.
        tick();
        pin = 24'h00_77_00;
        cfg_write(3'd2, 8'h55);
        pin = 24'h00_11_00; tick();
        check("R3 latch holds, strobe low", bus[11:8], 4'h7);
        check("R6 neighbour group passes", bus[15:12], 4'h1);
        addr_strb = 1'b1; pin = 24'h00_22_00; tick();
        check("R3 latch takes pin, strobe high", bus[11:8], 4'h2);
        pin = 24'h00_33_00; tick();
        check("R3 latch transparent", bus[11:8], 4'h3);
        addr_strb = 1'b0; pin = 24'h00_44_00; tick();
        check("R3 latch holds after fall", bus[11:8], 4'h3);

        // R4: group 3 register on product term 3.
        cfg_write(3'd6, 8'h08);
        cfg_write(3'd3, 8'hAA);
        pin = 24'h00_55_00; tick();
        check("R4 register holds, no edge", bus[15:12], 4'h4);
        pterm[3] = 1'b1; pin = 24'h00_66_00; tick();
        check("R4 register captures on rise", bus[15:12], 4'h6);
        pin = 24'h00_77_00; tick();
        check("R4 no capture while high", bus[15:12], 4'h6);
        pterm[3] = 1'b0; pin = 24'h00_88_00; tick();
        check("R4 no capture on fall", bus[15:12], 4'h6);
        pterm[3] = 1'b1; pin = 24'h00_99_00; tick();
        check("R4 second rise captures", bus[15:12], 4'h9);
        pterm[3] = 1'b0; tick();
        check("R6 other group strobe ignored", bus[11:8], 4'h3);

        // R5: unselected strobes have no effect.
        pterm[2] = 1'b1; pin = 24'h00_AA_00; tick();
        check("R5 pterm ignored on addr-strobe group", bus[11:8], 4'h3);
        pterm[2] = 1'b0; tick();
        addr_strb = 1'b1; pin = 24'h00_BB_00; tick();
        check("R5 addr strobe captures upper bits", bus[11:8], 4'hB);
        check("R5 addr strobe ignored on pterm group", bus[15:12], 4'h9);
        addr_strb = 1'b0; tick();

        // R7: write at address 7 changes nothing.
        cfg_write(3'd7, 8'h00);
        addr_strb = 1'b1; pin = 24'h00_CC_00; tick();
        check("R7 addr7 write left source select", bus[15:12], 4'h9);
        check("R7 addr7 write left latch mode", bus[11:8], 4'hC);
        addr_strb = 1'b0; tick();

        // R5: move group 2 onto its product term.
        pin = 24'h00_DD_00;
        cfg_write(3'd6, 8'h0C);
        addr_strb = 1'b1; tick();
        check("R5 group2 ignores addr strobe", bus[11:8], 4'hC);
        addr_strb = 1'b0;
        pterm[2] = 1'b1; pin = 24'h00_EE_00; tick();
        check("R5 group2 follows pterm2", bus[11:8], 4'hE);
        pterm[2] = 1'b0; tick();

        // R8: readback of every index.
        pin = 24'h5B_EE_C7; tick();
        do_read(2'd0, 8'hC7, "R8 read port0");
        do_read(2'd1, 8'h9E, "R8 read port1");
        do_read(2'd3, 8'h00, "R8 read index3 zero");
        do_read(2'd2, 8'h5B, "R8 read port2");
        pin = 24'h01_EE_C7; tick(); tick();
        check("R8 read data holds when idle", rd_data, 8'h5B);

        // R1: reset returns pass mode and address strobe select.
        rst_n = 1'b0; tick();
        rst_n = 1'b1; tick();
        pin = 24'h33_12_00; #1;
        check("R1 pass after second reset", bus, 24'h33_12_00);
        check("R1 read data cleared", rd_data, 8'h00);
        tick();
        if (exp_q.size() != 0) check("R8 scoreboard drained", exp_q.size(), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule